// File: doc/BRIEF.md
# Two-Wire EEPROM Block Transfer Sequencer

This controller turns one block request into the series of byte-level commands a two-wire serial memory needs. It drives an external byte engine that handles START, the bit shifting, ACK/NAK and STOP. The request carries a 7-bit device address, a one-byte starting offset, a byte count and a legacy-addressing bit. Write data is pulled from the requester one byte at a time through a pop strobe. Each read byte is presented with a one-cycle valid strobe. When the block finishes, the controller reports pass or fail together with a one-cycle done pulse.

A read first sets the offset with a write-addressed phase. After a bus-free gap it issues a repeated START with the read address and streams the bytes in. A write is cut into chunks of at most `CHUNK_MAX` bytes, and each chunk re-addresses the device. After each chunk's STOP the controller polls the device with read-addressed STARTs until the device acknowledges. It then fetches one byte and throws it away, which closes the device's internal write cycle. In legacy mode there is no offset byte: the offset rides in the address byte in place of the device address.

Top module: `eep_blk_xfer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `done`, `fail`, `be_go`, `wd_pop` and `rd_valid` are all low.
- R2: Each byte-engine command is a single-cycle `be_go` pulse with `be_op` = 2'b01 (write a byte, preceded by START when `be_start` is 1), 2'b10 (read a byte, answered with ACK when `be_last` is 0, or with NAK and then STOP when `be_last` is 1) or 2'b11 (STOP only). No new command is issued before `be_done` answers the previous one.
- R3: A non-legacy read sends, in order: START with byte {dev,0}, then the offset byte, then, no sooner than `GAP_CYCLES` cycles after the offset byte completes, START with byte {dev,1}. The R/W bit is the byte's LSB: 1 for read, 0 for write.
- R4: In legacy mode no offset byte is sent. The address byte is {offset[6:0], R/W}. For a read this is the only address phase.
- R5: A read of N bytes issues N read commands. All but the last have `be_last`=0 and the last has `be_last`=1. Each received byte appears on `rd_data` with a `rd_valid` pulse, in order.
- R6: During a read, a NAK on either START address byte is followed by a STOP command and ends with fail.
- R7: During a read, a NAK on the offset byte ends with fail at once, with no further command.
- R8: A write sends at most `CHUNK_MAX` data bytes per transaction, each taken from `wr_data` with a `wd_pop` pulse, and then a STOP. The next chunk addresses the device again with the offset advanced by the size of the previous chunk.
- R9: After each chunk's STOP, the controller sends START with {dev,1} (in both modes). Each NAK to it is followed by a STOP and another attempt.
- R10: The `POLL_MAX`-th NAK within one chunk's polling is followed by a STOP and ends with fail.
- R11: Once a poll is ACKed, one byte is read with `be_last`=1 and discarded; it never appears on `rd_valid`.
- R12: During a write, a NAK on the address, offset or any data byte is followed by a STOP and ends with fail.
- R13: A request of length 0 completes with pass and issues no byte-engine command.
- R14: `done` is a one-cycle pulse with `busy` low. `fail` is valid while `done` is high and holds until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_go | input | 1 | Start a block request (taken when idle) |
| req_read | input | 1 | 1 = read block, 0 = write block |
| req_legacy | input | 1 | Offset carried in the address byte, no offset byte |
| req_dev | input | 7 | Device address |
| req_offset | input | 8 | Starting offset within the device |
| req_len | input | LEN_W | Byte count |
| wr_data | input | 8 | Next write byte from the requester |
| wd_pop | output | 1 | `wr_data` consumed this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` is a new received byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (one cycle) |
| fail | output | 1 | Outcome of the last request, 1 = failed |
| be_go | output | 1 | Byte-engine command strobe |
| be_op | output | 2 | Command: 01 write, 10 read, 11 stop |
| be_start | output | 1 | Precede the write with START |
| be_last | output | 1 | Read: NAK then STOP instead of ACK |
| be_wbyte | output | 8 | Byte to write |
| be_done | input | 1 | Byte engine finished the command |
| be_nak | input | 1 | Written byte was not acknowledged |
| be_rbyte | input | 8 | Byte read by the engine |

## Verification
The bench builds the controller with `CHUNK_MAX`=4, `POLL_MAX`=3 and `GAP_CYCLES`=5, with a byte-engine model that answers two cycles after each command. The short poll limit lets a run reach write-cycle polling exhaustion in a few hundred cycles. The four-byte chunk lets six- and five-byte writes show re-addressing with an advanced offset in both addressing modes. The small gap keeps the repeated-start spacing measurable as a lower bound on command timestamps. NAKs can be injected at any chosen command index, and polls are NAKed a configurable number of times per chunk.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [1:0] {
    BE_NONE  = 2'b00,
    BE_WRITE = 2'b01,
    BE_READ  = 2'b10,
    BE_STOP  = 2'b11
  } be_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_DEVW,
    S_RD_OFF,
    S_RD_GAP,
    S_RD_DEVR,
    S_RD_DATA,
    S_WR_DEVW,
    S_WR_OFF,
    S_WR_DATA,
    S_WR_STOP,
    S_WR_POLL,
    S_WR_PSTOP,
    S_WR_DISC,
    S_STOPFAIL,
    S_FAIL,
    S_PASS
  } xfer_state_e;

endpackage

// File: rtl/eep_limit_ctr.sv
// Counts events up to LIMIT; last flags the final permitted count.
module eep_limit_ctr #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assign last = (count == W'(LIMIT - 1));

  // R10: the sequencer never counts past the limit
  assert_no_overrun_R10: assert property (@(posedge clk) disable iff (rst)
    inc |-> !last)
    else $error("limit counter stepped beyond its final count");
endmodule

// File: rtl/eep_len_track.sv
// Remaining byte count, running offset and bytes placed in the current chunk.
module eep_len_track #(
  parameter int LEN_W     = 8,
  parameter int CHUNK_MAX = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic [7:0]       off_in,
  input  logic             step,
  input  logic             chunk_clr,
  output logic [LEN_W-1:0] rem,
  output logic [7:0]       off,
  output logic             rem_one,
  output logic             chunk_end
);
  localparam int CW = (CHUNK_MAX > 1) ? $clog2(CHUNK_MAX) : 1;

  logic [CW-1:0] chunk_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem       <= '0;
      off       <= '0;
      chunk_cnt <= '0;
    end else if (load) begin
      rem       <= len_in;
      off       <= off_in;
      chunk_cnt <= '0;
    end else begin
      if (step) begin
        rem <= rem - 1'b1;
        off <= off + 8'd1;
      end
      if (chunk_clr)  chunk_cnt <= '0;
      else if (step)  chunk_cnt <= chunk_cnt + 1'b1;
    end
  end

  assign rem_one   = (rem == LEN_W'(1));
  assign chunk_end = rem_one || (chunk_cnt == CW'(CHUNK_MAX - 1));

  // R8: no byte is moved once the block length is used up
  assert_no_overstep_R8: assert property (@(posedge clk) disable iff (rst)
    step |-> (rem != '0))
    else $error("byte step with no bytes remaining");
endmodule

// File: rtl/eep_blk_xfer.sv
module eep_blk_xfer
  import eep_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int CHUNK_MAX  = 4,
  parameter int POLL_MAX   = 100,
  parameter int GAP_CYCLES = 3000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_go,
  input  logic             req_read,
  input  logic             req_legacy,
  input  logic [6:0]       req_dev,
  input  logic [7:0]       req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             wd_pop,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             be_go,
  output logic [1:0]       be_op,
  output logic             be_start,
  output logic             be_last,
  output logic [7:0]       be_wbyte,
  input  logic             be_done,
  input  logic             be_nak,
  input  logic [7:0]       be_rbyte
);

  xfer_state_e      state;
  logic             sent;
  logic             read_q, legacy_q;
  logic [6:0]       dev_q;
  be_op_e           op_q;

  logic [LEN_W-1:0] rem;
  logic [7:0]       off;
  logic             rem_one, chunk_end;
  logic             gap_last, poll_last;

  be_op_e           cmd_op;
  logic             cmd_start, cmd_last;
  logic [7:0]       cmd_byte;

  logic             fin;
  logic             trk_load, trk_step, trk_chunk_clr;
  logic             gap_clr, gap_inc, poll_clr, poll_inc;

  assign fin = sent && be_done;

  // Command each state puts on the byte engine.
  always_comb begin
    cmd_op    = BE_NONE;
    cmd_start = 1'b0;
    cmd_last  = 1'b0;
    cmd_byte  = 8'h00;
    case (state)
      S_RD_DEVW, S_WR_DEVW: begin
        cmd_op    = BE_WRITE;
        cmd_start = 1'b1;
        cmd_byte  = legacy_q ? {off[6:0], 1'b0} : {dev_q, 1'b0};
      end
      S_RD_OFF, S_WR_OFF: begin
        cmd_op   = BE_WRITE;
        cmd_byte = off;
      end
      S_RD_DEVR: begin
        cmd_op    = BE_WRITE;
        cmd_start = 1'b1;
        cmd_byte  = legacy_q ? {off[6:0], 1'b1} : {dev_q, 1'b1};
      end
      S_WR_POLL: begin
        cmd_op    = BE_WRITE;
        cmd_start = 1'b1;
        cmd_byte  = {dev_q, 1'b1};
      end
      S_WR_DATA: begin
        cmd_op   = BE_WRITE;
        cmd_byte = wr_data;
      end
      S_RD_DATA: begin
        cmd_op   = BE_READ;
        cmd_last = rem_one;
      end
      S_WR_DISC: begin
        cmd_op   = BE_READ;
        cmd_last = 1'b1;
      end
      S_WR_STOP, S_WR_PSTOP, S_STOPFAIL: cmd_op = BE_STOP;
      default: ;
    endcase
  end

  assign trk_load      = (state == S_IDLE) && req_go;
  assign trk_step      = fin && ((state == S_RD_DATA) ||
                                 ((state == S_WR_DATA) && !be_nak));
  assign trk_chunk_clr = (state == S_WR_DEVW);
  assign gap_clr       = (state != S_RD_GAP);
  assign gap_inc       = (state == S_RD_GAP) && !gap_last;
  assign poll_clr      = (state == S_WR_STOP);
  assign poll_inc      = (state == S_WR_POLL) && fin && be_nak && !poll_last;

  eep_len_track #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX)) u_track (
    .clk(clk), .rst(rst), .load(trk_load), .len_in(req_len), .off_in(req_offset),
    .step(trk_step), .chunk_clr(trk_chunk_clr), .rem(rem), .off(off),
    .rem_one(rem_one), .chunk_end(chunk_end)
  );

  eep_limit_ctr #(.LIMIT(GAP_CYCLES)) u_gap (
    .clk(clk), .rst(rst), .clr(gap_clr), .inc(gap_inc), .last(gap_last)
  );

  eep_limit_ctr #(.LIMIT(POLL_MAX)) u_poll (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      sent     <= 1'b0;
      read_q   <= 1'b0;
      legacy_q <= 1'b0;
      dev_q    <= '0;
      op_q     <= BE_NONE;
      be_go    <= 1'b0;
      be_start <= 1'b0;
      be_last  <= 1'b0;
      be_wbyte <= '0;
      wd_pop   <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      be_go    <= 1'b0;
      wd_pop   <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;

      if (cmd_op != BE_NONE && !sent) begin
        be_go    <= 1'b1;
        sent     <= 1'b1;
        op_q     <= cmd_op;
        be_start <= cmd_start;
        be_last  <= cmd_last;
        be_wbyte <= cmd_byte;
        wd_pop   <= (state == S_WR_DATA);
      end else if (fin) begin
        sent <= 1'b0;
      end

      case (state)
        S_IDLE: if (req_go) begin
          read_q   <= req_read;
          legacy_q <= req_legacy;
          dev_q    <= req_dev;
          fail     <= 1'b0;
          busy     <= 1'b1;
          if (req_len == '0)   state <= S_PASS;
          else if (!req_read)  state <= S_WR_DEVW;
          else if (req_legacy) state <= S_RD_DEVR;
          else                 state <= S_RD_DEVW;
        end
        S_RD_DEVW: if (fin) state <= be_nak ? S_STOPFAIL : S_RD_OFF;
        S_RD_OFF:  if (fin) state <= be_nak ? S_FAIL : S_RD_GAP;
        S_RD_GAP:  if (gap_last) state <= S_RD_DEVR;
        S_RD_DEVR: if (fin) state <= be_nak ? S_STOPFAIL : S_RD_DATA;
        S_RD_DATA: if (fin) begin
          rd_valid <= 1'b1;
          rd_data  <= be_rbyte;
          if (rem_one) state <= S_PASS;
        end
        S_WR_DEVW: if (fin) begin
          if (be_nak)        state <= S_STOPFAIL;
          else if (legacy_q) state <= S_WR_DATA;
          else               state <= S_WR_OFF;
        end
        S_WR_OFF:  if (fin) state <= be_nak ? S_STOPFAIL : S_WR_DATA;
        S_WR_DATA: if (fin) begin
          if (be_nak)         state <= S_STOPFAIL;
          else if (chunk_end) state <= S_WR_STOP;
        end
        S_WR_STOP:  if (fin) state <= S_WR_POLL;
        S_WR_POLL:  if (fin) begin
          if (!be_nak)        state <= S_WR_DISC;
          else if (poll_last) state <= S_STOPFAIL;
          else                state <= S_WR_PSTOP;
        end
        S_WR_PSTOP: if (fin) state <= S_WR_POLL;
        S_WR_DISC:  if (fin) state <= (rem == '0) ? S_PASS : S_WR_DEVW;
        S_STOPFAIL: if (fin) state <= S_FAIL;
        S_FAIL: begin
          done  <= 1'b1;
          fail  <= 1'b1;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        S_PASS: begin
          done  <= 1'b1;
          fail  <= 1'b0;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign be_op = op_q;

  // R2: a command strobe never lasts two cycles
  assert_go_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    be_go |=> !be_go)
    else $error("byte engine strobe held");

  // R3: repeated START of a read only after the full bus-free gap
  assert_gap_done_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_RD_DEVR && $past(state) == S_RD_GAP) |-> $past(gap_last))
    else $error("read address issued before gap elapsed");

  // R11: received bytes surface only for read requests
  assert_rdv_read_only_R11: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> read_q)
    else $error("read data presented during a write");

  // R14: completion pulse with the controller idle
  assert_done_idle_R14: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && state == S_IDLE))
    else $error("done while still busy");

  // R14: a failure flag only rises at completion
  assert_fail_at_done_R14: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> done)
    else $error("fail rose without done");

endmodule

// File: tb/tb_eep_blk_xfer.sv
`timescale 1ns/1ps
module tb_eep_blk_xfer;
  localparam int LEN_W = 8;
  localparam int CHUNK = 4;
  localparam int PMAX  = 3;
  localparam int GAP   = 5;
  localparam int LAT   = 2;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_go = 1'b0, req_read = 1'b0, req_legacy = 1'b0;
  logic [6:0] req_dev = DEV;
  logic [7:0] req_offset = 8'h00;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] wr_data;
  logic wd_pop, rd_valid, busy, done, fail, be_go, be_start, be_last;
  logic [7:0] rd_data, be_wbyte;
  logic [1:0] be_op;
  logic be_done = 1'b0, be_nak = 1'b0;
  logic [7:0] be_rbyte = 8'h00;

  always #10 clk = ~clk;

  eep_blk_xfer #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK), .POLL_MAX(PMAX), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst(rst), .req_go(req_go), .req_read(req_read), .req_legacy(req_legacy),
    .req_dev(req_dev), .req_offset(req_offset), .req_len(req_len), .wr_data(wr_data),
    .wd_pop(wd_pop), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .fail(fail), .be_go(be_go), .be_op(be_op), .be_start(be_start), .be_last(be_last),
    .be_wbyte(be_wbyte), .be_done(be_done), .be_nak(be_nak), .be_rbyte(be_rbyte)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic log_clr = 1'b0;
  int nak_idx = -1, poll_cfg = 0;
  logic poll_mode = 1'b0;

  // command log kept by the engine model
  int lg_op[0:127], lg_st[0:127], lg_la[0:127], lg_by[0:127], lg_t[0:127];
  int nlog = 0, poll_run = 0, rcount = 0, eng_cnt = 0;
  logic eng_busy = 1'b0, pend_nak = 1'b0, pend_rd = 1'b0;
  int rd_got[0:63];
  int nrd = 0, npop = 0;
  logic [7:0] wbuf[0:63];
  int exp_op[0:127], exp_st[0:127], exp_la[0:127], exp_by[0:127];
  int nexp = 0;

  assign wr_data = wbuf[npop[5:0]];

  function automatic logic [7:0] rb(input int k);
    return 8'((k * 37 + 90) & 255);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // byte engine and device model
  always @(posedge clk) begin : eng
    logic nk;
    be_done <= 1'b0;
    if (log_clr) begin
      nlog <= 0; poll_run <= 0; rcount <= 0; eng_busy <= 1'b0;
    end else if (be_go) begin
      lg_op[nlog] <= int'(be_op); lg_st[nlog] <= int'(be_start);
      lg_la[nlog] <= int'(be_last); lg_by[nlog] <= int'(be_wbyte); lg_t[nlog] <= cyc;
      nk = (nlog == nak_idx);
      if (poll_mode && be_op == 2'b01 && be_start && be_wbyte[0]) begin
        if (poll_run < poll_cfg) begin nk = 1'b1; poll_run <= poll_run + 1; end
        else poll_run <= 0;
      end
      nlog <= nlog + 1;
      pend_nak <= nk; pend_rd <= (be_op == 2'b10);
      eng_busy <= 1'b1; eng_cnt <= LAT;
    end else if (eng_busy) begin
      if (eng_cnt == 0) begin
        be_done <= 1'b1; be_nak <= pend_nak; be_rbyte <= rb(rcount);
        if (pend_rd) rcount <= rcount + 1;
        eng_busy <= 1'b0;
      end else eng_cnt <= eng_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (log_clr) begin nrd <= 0; npop <= 0; end
    else begin
      if (rd_valid) begin rd_got[nrd] <= int'(rd_data); nrd <= nrd + 1; end
      if (wd_pop) npop <= npop + 1;
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic ex(input int op, input int st, input int la, input int by);
    exp_op[nexp] = op; exp_st[nexp] = st; exp_la[nexp] = la; exp_by[nexp] = by;
    nexp++;
  endtask

  task automatic ex_data(input int base, input int cnt);
    for (int i = 0; i < cnt; i++) ex(1, 0, 0, int'(wbuf[base + i]));
  endtask

  task automatic cmp_log(input string req);
    chk(req, nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++) begin
      chk(req, lg_op[i], exp_op[i]);
      if (exp_op[i] == 1) begin
        chk(req, lg_st[i], exp_st[i]);
        chk(req, lg_by[i], exp_by[i]);
      end
      if (exp_op[i] == 2) chk(req, lg_la[i], exp_la[i]);
    end
  endtask

  // issue a request and wait for completion; returns fail flag
  task automatic run_req(input logic rd, input logic leg, input logic [7:0] offv,
                         input int len, output int f);
    int w;
    @(negedge clk);
    log_clr = 1'b1; nexp = 0;
    @(negedge clk);
    log_clr = 1'b0;
    req_read = rd; req_legacy = leg; req_offset = offv; req_len = LEN_W'(len);
    req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
    w = 0;
    while (!done && w < 4000) begin @(negedge clk); w++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R14: no done (actual 0 expected 1)");
      f = -1;
    end else begin
      f = int'(fail);
      chk("R14 busy at done", int'(busy), 0);
      @(negedge clk);
      chk("R14 done one cycle", int'(done), 0);
      chk("R14 fail held", int'(fail), f);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic fill(input int base);
    for (int i = 0; i < 64; i++) wbuf[i] = 8'(base + i * 3);
  endtask

  task automatic t_read_normal;
    int f;
    nak_idx = -1; poll_mode = 0;
    run_req(1, 0, 8'h10, 3, f);
    chk("R5 read pass", f, 0);
    ex(1, 1, 0, 'hA0); ex(1, 0, 0, 'h10); ex(1, 1, 0, 'hA1);
    ex(2, 0, 0, 0); ex(2, 0, 0, 0); ex(2, 0, 1, 0);
    cmp_log("R3");
    if (nlog >= 3) begin
      n_chk++;
      if (lg_t[2] - lg_t[1] < GAP + LAT + 1) begin
        n_bad++;
        $display("FAIL R3: gap actual %0d expected >= %0d", lg_t[2] - lg_t[1], GAP + LAT + 1);
      end
    end
    chk("R5 count", nrd, 3);
    for (int i = 0; i < 3; i++) chk("R5 data", rd_got[i], int'(rb(i)));
  endtask

  task automatic t_read_legacy;
    int f;
    nak_idx = -1; poll_mode = 0;
    run_req(1, 1, 8'h23, 2, f);
    chk("R4 pass", f, 0);
    ex(1, 1, 0, 'h47); ex(2, 0, 0, 0); ex(2, 0, 1, 0);
    cmp_log("R4");
    chk("R4 count", nrd, 2);
    for (int i = 0; i < 2; i++) chk("R5 legacy data", rd_got[i], int'(rb(i)));
  endtask

  task automatic t_read_one;
    int f;
    nak_idx = -1; poll_mode = 0;
    run_req(1, 0, 8'h05, 1, f);
    chk("R5 single pass", f, 0);
    ex(1, 1, 0, 'hA0); ex(1, 0, 0, 'h05); ex(1, 1, 0, 'hA1); ex(2, 0, 1, 0);
    cmp_log("R5");
    chk("R5 single data", rd_got[0], int'(rb(0)));
  endtask

  task automatic t_read_nak_addr;
    int f;
    nak_idx = 0; poll_mode = 0;
    run_req(1, 0, 8'h10, 2, f);
    chk("R6 fail", f, 1);
    ex(1, 1, 0, 'hA0); ex(3, 0, 0, 0);
    cmp_log("R6");
    chk("R6 no data", nrd, 0);
  endtask

  task automatic t_read_nak_repeat;
    int f;
    nak_idx = 2; poll_mode = 0;
    run_req(1, 0, 8'h10, 2, f);
    chk("R6 repeated start fail", f, 1);
    ex(1, 1, 0, 'hA0); ex(1, 0, 0, 'h10); ex(1, 1, 0, 'hA1); ex(3, 0, 0, 0);
    cmp_log("R6");
  endtask

  task automatic t_read_nak_off;
    int f;
    nak_idx = 1; poll_mode = 0;
    run_req(1, 0, 8'h10, 2, f);
    chk("R7 fail", f, 1);
    ex(1, 1, 0, 'hA0); ex(1, 0, 0, 'h10);
    cmp_log("R7");
  endtask

  task automatic t_write_normal;
    int f;
    nak_idx = -1; poll_mode = 1; poll_cfg = 2; fill('hC0);
    run_req(0, 0, 8'h10, 6, f);
    chk("R8 pass", f, 0);
    ex(1, 1, 0, 'hA0); ex(1, 0, 0, 'h10); ex_data(0, 4); ex(3, 0, 0, 0);
    for (int p = 0; p < 2; p++) begin ex(1, 1, 0, 'hA1); ex(3, 0, 0, 0); end
    ex(1, 1, 0, 'hA1); ex(2, 0, 1, 0);
    ex(1, 1, 0, 'hA0); ex(1, 0, 0, 'h14); ex_data(4, 2); ex(3, 0, 0, 0);
    for (int p = 0; p < 2; p++) begin ex(1, 1, 0, 'hA1); ex(3, 0, 0, 0); end
    ex(1, 1, 0, 'hA1); ex(2, 0, 1, 0);
    cmp_log("R9");
    chk("R8 pops", npop, 6);
    chk("R11 discard hidden", nrd, 0);
  endtask

  task automatic t_write_legacy;
    int f;
    nak_idx = -1; poll_mode = 1; poll_cfg = 0; fill('h11);
    run_req(0, 1, 8'h30, 5, f);
    chk("R4 write pass", f, 0);
    ex(1, 1, 0, 'h60); ex_data(0, 4); ex(3, 0, 0, 0); ex(1, 1, 0, 'hA1); ex(2, 0, 1, 0);
    ex(1, 1, 0, 'h68); ex_data(4, 1); ex(3, 0, 0, 0); ex(1, 1, 0, 'hA1); ex(2, 0, 1, 0);
    cmp_log("R8");
    chk("R11 legacy discard hidden", nrd, 0);
  endtask

  task automatic t_write_four;
    int f;
    nak_idx = -1; poll_mode = 1; poll_cfg = 1; fill('h70);
    run_req(0, 0, 8'h00, 4, f);
    chk("R8 single chunk pass", f, 0);
    ex(1, 1, 0, 'hA0); ex(1, 0, 0, 'h00); ex_data(0, 4); ex(3, 0, 0, 0);
    ex(1, 1, 0, 'hA1); ex(3, 0, 0, 0); ex(1, 1, 0, 'hA1); ex(2, 0, 1, 0);
    cmp_log("R11");
  endtask

  task automatic t_poll_exhaust;
    int f;
    nak_idx = -1; poll_mode = 1; poll_cfg = PMAX; fill('h20);
    run_req(0, 0, 8'h00, 2, f);
    chk("R10 fail", f, 1);
    ex(1, 1, 0, 'hA0); ex(1, 0, 0, 'h00); ex_data(0, 2); ex(3, 0, 0, 0);
    for (int p = 0; p < PMAX; p++) begin ex(1, 1, 0, 'hA1); ex(3, 0, 0, 0); end
    cmp_log("R10");
  endtask

  task automatic t_write_nak_data;
    int f;
    nak_idx = 3; poll_mode = 1; poll_cfg = 0; fill('h40);
    run_req(0, 0, 8'h08, 3, f);
    chk("R12 data nak fail", f, 1);
    ex(1, 1, 0, 'hA0); ex(1, 0, 0, 'h08); ex_data(0, 2); ex(3, 0, 0, 0);
    cmp_log("R12");
  endtask

  task automatic t_write_nak_off;
    int f;
    nak_idx = 1; poll_mode = 1; poll_cfg = 0; fill('h40);
    run_req(0, 0, 8'h08, 3, f);
    chk("R12 offset nak fail", f, 1);
    ex(1, 1, 0, 'hA0); ex(1, 0, 0, 'h08); ex(3, 0, 0, 0);
    cmp_log("R12");
  endtask

  task automatic t_len_zero;
    int f;
    nak_idx = -1; poll_mode = 0;
    run_req(0, 0, 8'h00, 0, f);
    chk("R13 pass", f, 0);
    chk("R13 no commands", nlog, 0);
  endtask

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 go", int'(be_go), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 fail", int'(fail), 0);
    chk("R1 pop", int'(wd_pop), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    t_read_normal;
    t_read_legacy;
    t_read_one;
    t_read_nak_addr;
    t_read_nak_repeat;
    t_read_nak_off;
    t_write_normal;
    t_write_legacy;
    t_write_four;
    t_poll_exhaust;
    t_write_nak_data;
    t_write_nak_off;
    t_len_zero;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule